// File: doc/BRIEF.md
# Integer ALU with Status Flags

This block performs one integer operation per accepted request on two operands: add, add with carry, subtract, subtract with borrow, bitwise AND, OR and XOR, or compare. Alongside the result it works out six status bits (carry, overflow, sign, zero, a nibble carry out of bit 3 into bit 4, and even parity of the low result byte). It keeps these bits in a flag register, and later operations can read that register. The chained-arithmetic operations take their incoming carry or borrow from the stored carry flag, so a wide sum can be built from a run of narrow requests.

Requests arrive on a valid/ready stream. A request moves when `in_valid` and `in_ready` are both high at a rising clock edge. Results leave on a second valid/ready stream held in a single output register. `in_ready` is high whenever that register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output holds steady and no new request is taken. A compare request changes only the flags. It creates no output beat, and `out_data` keeps the last arithmetic or logic result. The flag register is written only when the request carries `in_flag_en` high. The flag register drives the plain `flags` output.

Top module: `flag_alu`

## Requirements
- R1: ADD (op 0) and SUB (op 2) give the operand sum or difference modulo 2^W on `out_data` after the accepting edge. Carry (flags bit 0) is set on an unsigned carry out of the sum, or when a difference needs a borrow (first operand below second plus incoming borrow).
- R2: ADC (op 1) adds the stored carry flag as carry in, and SBB (op 3) subtracts it as a borrow. A request accepted on the edge right after a flag write uses the newly written carry.
- R3: Overflow (flags bit 1) is set for add when both operands share a sign and the result sign differs. For subtract and compare it is set when the operand signs differ and the result sign differs from the first operand.
- R4: Sign (flags bit 2) equals the result's top bit, and zero (flags bit 3) is set exactly when the result is all zeros.
- R5: Nibble carry (flags bit 4) is set for add when the low four bits plus carry in exceed 15. For subtract it is set when the first operand's low four bits are below the second's plus the borrow.
- R6: Parity (flags bit 5) is 1 when the low 8 bits of the result hold an even number of ones.
- R7: AND (op 4), OR (op 5) and XOR (op 6) clear carry, overflow and nibble carry, and set sign, zero and parity from their result.
- R8: Compare (op 7) sets all six flags as SUB would. It produces no output beat and leaves `out_data` unchanged.
- R9: A request accepted with `in_flag_en` low leaves `flags` unchanged.
- R10: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_valid` and `out_data` hold.
- R11: After reset, `flags`, `out_data` and `out_valid` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_op | input | 3 | Operation code (0 ADD, 1 ADC, 2 SUB, 3 SBB, 4 AND, 5 OR, 6 XOR, 7 CMP) |
| in_a | input | W | First operand |
| in_b | input | W | Second operand |
| in_flag_en | input | 1 | Write the flag register with this request's flags |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Sink takes the result beat |
| out_data | output | W | Result register (last non-compare result) |
| flags | output | 6 | Stored flags: bit0 carry, 1 overflow, 2 sign, 3 zero, 4 nibble carry, 5 parity |

## Verification
Two things can fall on the same edge here. One is a flag-register write. The other is the acceptance of an ADC or SBB that reads the carry produced by the request just before it. Back-to-back requests with no idle cycle provoke this, both in directed chains and in a long mixed run. The second overlap is a drain of the output register together with a new acceptance (or a compare that pops without pushing). A pseudo-random `out_ready` pattern provokes it. A behavioural model, updated each edge from the sampled handshake, judges `out_valid`, `out_data`, `in_ready` and every flag bit in every cycle.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_ADC = 3'd1,
    OP_SUB = 3'd2,
    OP_SBB = 3'd3,
    OP_AND = 3'd4,
    OP_OR  = 3'd5,
    OP_XOR = 3'd6,
    OP_CMP = 3'd7
  } alu_op_e;

  typedef struct packed {
    logic par;   // bit 5
    logic nib;   // bit 4
    logic zro;   // bit 3
    logic sgn;   // bit 2
    logic ovf;   // bit 1
    logic cry;   // bit 0
  } alu_flags_t;

  localparam int FLAG_BITS   = $bits(alu_flags_t);
  localparam int PARITY_SPAN = 8;

  function automatic logic op_is_logic(alu_op_e op);
    return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
  endfunction

  function automatic logic op_is_sub(alu_op_e op);
    return (op == OP_SUB) || (op == OP_SBB) || (op == OP_CMP);
  endfunction

  function automatic logic op_uses_carry(alu_op_e op);
    return (op == OP_ADC) || (op == OP_SBB);
  endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         subtract,
  input  logic         chain_en,
  input  logic         carry_flag,
  output logic [W-1:0] res,
  output logic         cry,
  output logic         ovf,
  output logic         nib
);
  localparam int NIB = 4;

  logic [W-1:0] b_eff;
  logic         c_in;
  logic [W:0]   total;

  always_comb begin
    b_eff = subtract ? ~b : b;
    // incoming borrow is applied as an inverted carry into the adder
    c_in  = subtract ? ~(chain_en & carry_flag) : (chain_en & carry_flag);
    total = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, c_in};
    res   = total[W-1:0];
    cry   = total[W] ^ subtract;
    ovf   = (a[W-1] == b_eff[W-1]) && (res[W-1] != a[W-1]);
    nib   = a[NIB] ^ b[NIB] ^ res[NIB];
  end

endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   sel,
  output logic [W-1:0] res
);
  always_comb begin
    unique case (sel)
      2'd0:    res = a & b;
      2'd1:    res = a | b;
      2'd2:    res = a ^ b;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/alu_flag_gen.sv
module alu_flag_gen #(
  parameter int W  = 16,
  parameter int PW = 8
) (
  input  logic [W-1:0] res,
  output logic         sgn,
  output logic         zro,
  output logic         par
);
  localparam int SPAN = (PW < W) ? PW : W;

  logic [SPAN-1:0] low_bits;

  generate
    for (genvar i = 0; i < SPAN; i++) begin : g_low
      assign low_bits[i] = res[i];
    end
  endgenerate

  assign sgn = res[W-1];
  assign zro = (res == '0);
  assign par = ~(^low_bits);
endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [2:0]           in_op,
  input  logic [W-1:0]         in_a,
  input  logic [W-1:0]         in_b,
  input  logic                 in_flag_en,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [W-1:0]         out_data,
  output logic [FLAG_BITS-1:0] flags
);
  localparam int LOG_SEL_W = 2;

  alu_op_e    op;
  alu_flags_t flags_q;
  alu_flags_t flags_d;
  logic       accept;

  logic [W-1:0] as_res;
  logic         as_cry, as_ovf, as_nib;
  logic [W-1:0] lg_res;
  logic [W-1:0] res_d;
  logic         fg_sgn, fg_zro, fg_par;
  logic [LOG_SEL_W-1:0] lg_sel;

  assign op       = alu_op_e'(in_op);
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign lg_sel   = in_op[LOG_SEL_W-1:0];

  alu_addsub #(.W(W)) u_addsub (
    .a          (in_a),
    .b          (in_b),
    .subtract   (op_is_sub(op)),
    .chain_en   (op_uses_carry(op)),
    .carry_flag (flags_q.cry),
    .res        (as_res),
    .cry        (as_cry),
    .ovf        (as_ovf),
    .nib        (as_nib)
  );

  alu_logic_unit #(.W(W)) u_logic (
    .a   (in_a),
    .b   (in_b),
    .sel (lg_sel),
    .res (lg_res)
  );

  assign res_d = op_is_logic(op) ? lg_res : as_res;

  alu_flag_gen #(.W(W), .PW(PARITY_SPAN)) u_fgen (
    .res (res_d),
    .sgn (fg_sgn),
    .zro (fg_zro),
    .par (fg_par)
  );

  always_comb begin
    flags_d.sgn = fg_sgn;
    flags_d.zro = fg_zro;
    flags_d.par = fg_par;
    if (op_is_logic(op)) begin
      flags_d.cry = 1'b0;
      flags_d.ovf = 1'b0;
      flags_d.nib = 1'b0;
    end else begin
      flags_d.cry = as_cry;
      flags_d.ovf = as_ovf;
      flags_d.nib = as_nib;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q   <= '0;
      out_data  <= '0;
      out_valid <= 1'b0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (accept) begin
        if (in_flag_en) flags_q <= flags_d;
        if (op != OP_CMP) begin
          out_data  <= res_d;
          out_valid <= 1'b1;
        end
      end
    end
  end

  assign flags = flags_q;

  // R10: stalled output holds and blocks the input side
  a_r10_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
  a_r10_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R8: compare never writes the result register or makes a beat by itself
  a_r8_cmp_keeps_result: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op == OP_CMP) |=> $stable(out_data));

  // R9: disabled flag update leaves the flag register alone
  a_r9_flags_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !in_flag_en) |=> $stable(flags));

  // R7: logic operations clear the arithmetic flags
  a_r7_logic_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_flag_en && op_is_logic(op)) |=> (!flags[0] && !flags[1] && !flags[4]));

  // R4: stored sign agrees with the stored result
  a_r4_sign_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_flag_en && op != OP_CMP) |=> (flags[2] == out_data[W-1]));

  // R6: stored parity agrees with the low byte of the stored result
  a_r6_parity_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_flag_en && op != OP_CMP) |=> (flags[5] == ~(^out_data[PARITY_SPAN-1:0])));

endmodule

// File: tb/flag_alu_bench.sv
module flag_alu_bench;
  localparam int W = 16;
  localparam longint unsigned MASK = (64'd1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [2:0]   in_op = 3'd0;
  logic [W-1:0] in_a = '0;
  logic [W-1:0] in_b = '0;
  logic         in_flag_en = 1'b0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [W-1:0] out_data;
  logic [5:0]   flags;

  int checks = 0;
  int failures = 0;
  string ctx = "R11";
  bit running = 1'b0;
  bit rand_ready = 1'b0;

  // behavioural model state
  bit              m_valid = 0;
  longint unsigned m_data  = 0;
  bit [5:0]        m_flags = 0;
  bit              m_acc   = 0;

  always #10 clk = ~clk;

  flag_alu #(.W(W)) u_flag_alu (
    .clk, .rst_n, .in_valid, .in_ready, .in_op, .in_a, .in_b, .in_flag_en,
    .out_valid, .out_ready, .out_data, .flags
  );

  task automatic check(string tag, longint unsigned act, longint unsigned exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s (ctx %s) actual=%0h expected=%0h at %0t", tag, ctx, act, exp, $time);
    end
  endtask

  function automatic bit [5:0] calc(input int op, input longint unsigned a,
                                    input longint unsigned b, input bit cf,
                                    output longint unsigned r);
    bit c = 0, o = 0, s, z, n = 0, p;
    longint unsigned ci;
    longint unsigned full;
    bit sa, sb, sr;
    sa = a[W-1]; sb = b[W-1];
    ci = (op == 1 || op == 3) ? longint'(cf) : 0;
    case (op)
      0, 1: begin
        full = a + b + ci; r = full & MASK;
        c = ((full >> W) & 1) != 0;
        n = ((a & 15) + (b & 15) + ci) > 15;
        sr = r[W-1]; o = (sa == sb) && (sr != sa);
      end
      2, 3, 7: begin
        full = a - b - ci; r = full & MASK;
        c = a < (b + ci);
        n = (a & 15) < ((b & 15) + ci);
        sr = r[W-1]; o = (sa != sb) && (sr != sa);
      end
      4: r = a & b;
      5: r = a | b;
      default: r = a ^ b;
    endcase
    s = r[W-1];
    z = (r == 0);
    p = ($countones(r & 255) % 2) == 0;
    return {p, n, z, s, o, c};
  endfunction

  // model update on every edge from the sampled handshake
  always @(posedge clk) begin
    bit rdy;
    longint unsigned r;
    bit [5:0] f;
    m_acc = 0;
    if (!rst_n) begin
      m_valid = 0; m_data = 0; m_flags = 0;
    end else begin
      rdy = !m_valid || out_ready;
      m_acc = in_valid && rdy;
      if (m_valid && out_ready) m_valid = 0;
      if (m_acc) begin
        f = calc(int'(in_op), longint'(in_a), longint'(in_b), m_flags[0], r);
        if (in_flag_en) m_flags = f;
        if (in_op != 3'd7) begin m_data = r; m_valid = 1; end
      end
    end
  end

  // per-cycle comparison, away from the edge
  always @(posedge clk) begin
    #5;
    if (running) begin
      check("R10", out_valid, m_valid);
      check("R10", in_ready, !m_valid || out_ready);
      check("R1",  out_data, m_data);
      check("R1",  flags[0], m_flags[0]);
      check("R3",  flags[1], m_flags[1]);
      check("R4",  flags[2], m_flags[2]);
      check("R4",  flags[3], m_flags[3]);
      check("R5",  flags[4], m_flags[4]);
      check("R6",  flags[5], m_flags[5]);
    end
  end

  always @(negedge clk) begin
    if (rand_ready) out_ready <= ($urandom % 3) != 0;
  end

  task automatic send(input int op, input int a, input int b, input bit fen);
    @(negedge clk);
    in_valid <= 1'b1; in_op <= 3'(op); in_a <= W'(a); in_b <= W'(b); in_flag_en <= fen;
    forever begin
      @(posedge clk); #1;
      if (m_acc) break;
    end
    @(negedge clk);
    in_valid <= 1'b0;
  endtask

  initial begin
    #(20 * 190000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    // R11: reset state
    check("R11", flags, 0);
    check("R11", out_valid, 0);
    check("R11", out_data, 0);
    @(negedge clk); rst_n <= 1'b1;
    running = 1'b1;

    ctx = "R1";
    send(0, 'hffff, 'h0001, 1);           // carry out, zero, nibble carry
    check("R1", flags[0], 1);
    ctx = "R2";
    send(1, 'h0000, 'h0000, 1);           // consumes carry just written
    check("R2", out_data, 1);
    ctx = "R1";
    send(2, 'h0000, 'h0001, 1);           // borrow
    check("R1", out_data, 'hffff);
    check("R1", flags[0], 1);
    ctx = "R2";
    send(3, 'h0005, 'h0001, 1);           // 5-1-1
    check("R2", out_data, 3);
    ctx = "R3";
    send(0, 'h7fff, 'h0001, 1);
    check("R3", flags[1], 1);
    send(2, 'h8000, 'h0001, 1);
    check("R3", flags[1], 1);
    ctx = "R5";
    send(0, 'h000f, 'h0001, 1);
    check("R5", flags[4], 1);
    ctx = "R6";
    send(5, 'h0103, 'h0000, 1);
    check("R6", flags[5], 1);
    ctx = "R7";
    send(0, 'hffff, 'h0001, 1);
    send(4, 'h8f0f, 'hf0ff, 1);
    check("R7", flags[0], 0);
    check("R7", flags[4], 0);
    check("R7", out_data, 'h800f);
    ctx = "R8";
    send(0, 'h1234, 'h0000, 1);
    send(7, 'h0001, 'h0002, 1);
    check("R8", out_data, 'h1234);
    check("R8", flags[0], 1);
    ctx = "R9";
    send(0, 'hffff, 'h0001, 0);
    check("R9", flags[0], 1);
    check("R9", out_data, 0);

    // R10 / R2: mixed traffic with back-pressure and back-to-back chains
    ctx = "R10";
    rand_ready = 1'b1;
    for (int i = 0; i < 400; i++) begin
      send($urandom % 8, $urandom, ($urandom % 4 == 0) ? 'hffff : $urandom, ($urandom % 5) != 0);
    end
    rand_ready = 1'b0;
    @(negedge clk); out_ready <= 1'b1;
    repeat (4) @(posedge clk);
    #6;
    running = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule